// File: doc/BRIEF.md
# Word-Serial Multiply-Accumulate Datapath

This block is the arithmetic core of a word-serial big-integer engine. Each clock cycle it takes two 16-bit operand words, one from each port of a dual-ported working memory. It combines them under a control word and updates a 40-bit accumulator. The operation can be a single-cycle 16x16 multiply, a doubled multiply for the cross terms of a squaring, or a plain addition. A second adder then folds in a feedback value taken from the accumulator. That value is the accumulator itself, the accumulator shifted down by one word, or nothing. This lets a multi-word product be built one column at a time, with the carry word shifted down between columns.

The same datapath also does 16-bit XOR, AND and OR for hash rounds. Either operand can be replaced by the constant zero, one or all-ones instead of the port word. The accumulator's low word and second word are always presented as write data for the two memory ports. Two write-enable bits in the control word are registered so that they line up with that data. An external sequencer drives the control word. The memory belongs to the surrounding system.

Top module: `wsmac_datapath`

## Requirements
- R1: While rst_n is low the accumulator is zero, wr_a_en and wr_b_en are low, and wr_a_data and wr_b_data read zero.
- R2: Each operand is chosen by a 2-bit field, ctl_word[4:3] for operand A and ctl_word[6:5] for operand B: code 0 passes the port word (rd_a or rd_b), 1 gives 0, 2 gives 1 and 3 gives 0xFFFF.
- R3: With ctl_word[2:0]=0 the next accumulator is A*B plus the feedback value, taken modulo 2^40. The feedback field ctl_word[8:7] gives: code 1 the accumulator, code 2 the accumulator shifted right by 16, codes 0 and 3 zero.
- R4: With ctl_word[2:0]=1 the next accumulator is 2*A*B plus the feedback value of R3, modulo 2^40.
- R5: With ctl_word[2:0]=2 the next accumulator is A+B plus the feedback value of R3, modulo 2^40.
- R6: Codes 3, 4 and 5 of ctl_word[2:0] load the accumulator with A XOR B, A AND B and A OR B, zero-extended. The feedback field has no effect on them.
- R7: The accumulator keeps its value when ctl_word[9] (accumulate enable) is 0, and also when ctl_word[2:0] is 6 or 7.
- R8: The accumulator is updated on the rising clock edge at which the control word is sampled. From then on wr_a_data shows accumulator bits 15:0 and wr_b_data shows bits 31:16.
- R9: wr_a_en and wr_b_en take the values of ctl_word[10] and ctl_word[11] at the same edge that updates the accumulator, so each enable accompanies the data it refers to.
- R10: Accumulator bits 39:32 keep carries out of bit 31 across many cycles, and a shift-down by 16 brings them into view on the write ports.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_word | input | 12 | Operation, operand selects, feedback, enable and write requests |
| rd_a | input | 16 | Operand word read from memory port A |
| rd_b | input | 16 | Operand word read from memory port B |
| wr_a_en | output | 1 | Write request for memory port A |
| wr_a_data | output | 16 | Accumulator bits 15:0 |
| wr_b_en | output | 1 | Write request for memory port B |
| wr_b_data | output | 16 | Accumulator bits 31:16 |

## Verification
Every result shows up exactly one rising edge after its control word and operands are applied. The accumulator and both write enables are registered on that edge, and nothing between them and the ports adds delay. The bench applies stimulus on the falling edge. It predicts the accumulator from the arithmetic in the requirements and compares both data words and both enables 1 ns after the next rising edge. Hold cases are checked the same way: a cycle with the enable low, or with code 6 or 7, must leave the ports unchanged at that sample. The multiplier variant that is built from partial products runs beside the default one, so both get the same cycle-by-cycle checks.

// File: rtl/wsmac_pkg.sv
package wsmac_pkg;

   localparam int CTL_W = 12;

   typedef enum logic [2:0] {
      OP_MUL  = 3'd0,
      OP_MUL2 = 3'd1,
      OP_ADD  = 3'd2,
      OP_XOR  = 3'd3,
      OP_AND  = 3'd4,
      OP_OR   = 3'd5,
      OP_NOP0 = 3'd6,
      OP_NOP1 = 3'd7
   } op_e;

   typedef enum logic [1:0] {
      SRC_PORT = 2'd0,
      SRC_ZERO = 2'd1,
      SRC_ONE  = 2'd2,
      SRC_ONES = 2'd3
   } src_e;

   typedef enum logic [1:0] {
      FB_NONE  = 2'd0,
      FB_ACC   = 2'd1,
      FB_SHR   = 2'd2,
      FB_NONE2 = 2'd3
   } fb_e;

   typedef struct packed {
      logic wr_b;
      logic wr_a;
      logic acc_en;
      fb_e  fb;
      src_e src_b;
      src_e src_a;
      op_e  op;
   } ctl_t;

endpackage

// File: rtl/wsmac_opmux.sv
module wsmac_opmux
   import wsmac_pkg::*;
#(
   parameter int W = 16
) (
   input  src_e         sel,
   input  logic [W-1:0] port_word,
   output logic [W-1:0] operand
);

   always_comb begin
      case (sel)
         SRC_PORT: operand = port_word;
         SRC_ZERO: operand = '0;
         SRC_ONE:  operand = W'(1);
         default:  operand = {W{1'b1}};
      endcase
   end

endmodule

// File: rtl/wsmac_arith.sv
module wsmac_arith
   import wsmac_pkg::*;
#(
   parameter int W        = 16,
   parameter int ACC_W    = 40,
   parameter int MUL_IMPL = 0
) (
   input  op_e              op,
   input  logic [W-1:0]     opa,
   input  logic [W-1:0]     opb,
   output logic [ACC_W-1:0] sum1,
   output logic [W-1:0]     lword,
   output logic             is_logic,
   output logic             is_hold
);

   localparam int PW = 2 * W;

   logic [PW-1:0]    prod;
   logic [ACC_W-1:0] term_x;
   logic [ACC_W-1:0] term_y;

   generate
      if (MUL_IMPL == 0) begin : g_mul_op
         assign prod = PW'(opa) * PW'(opb);
      end else begin : g_mul_pp
         logic [PW-1:0] pp [W];
         for (genvar i = 0; i < W; i++) begin : g_row
            assign pp[i] = opb[i] ? (PW'(opa) << i) : '0;
         end
         always_comb begin
            prod = '0;
            for (int i = 0; i < W; i++) begin
               prod = prod + pp[i];
            end
         end
      end
   endgenerate

   always_comb begin
      case (op)
         OP_MUL: begin
            term_x = ACC_W'(prod);
            term_y = '0;
         end
         OP_MUL2: begin
            term_x = ACC_W'(prod);
            term_y = ACC_W'(prod);
         end
         OP_ADD: begin
            term_x = ACC_W'(opa);
            term_y = ACC_W'(opb);
         end
         default: begin
            term_x = '0;
            term_y = '0;
         end
      endcase
   end

   assign sum1 = term_x + term_y;

   always_comb begin
      case (op)
         OP_XOR:  lword = opa ^ opb;
         OP_AND:  lword = opa & opb;
         OP_OR:   lword = opa | opb;
         default: lword = '0;
      endcase
   end

   assign is_logic = (op == OP_XOR) || (op == OP_AND) || (op == OP_OR);
   assign is_hold  = (op == OP_NOP0) || (op == OP_NOP1);

endmodule

// File: rtl/wsmac_accum.sv
module wsmac_accum
   import wsmac_pkg::*;
#(
   parameter int W     = 16,
   parameter int ACC_W = 40
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             acc_en,
   input  fb_e              fb,
   input  logic             is_logic,
   input  logic             is_hold,
   input  logic [ACC_W-1:0] sum1,
   input  logic [W-1:0]     lword,
   output logic [W-1:0]     acc_lo,
   output logic [W-1:0]     acc_hi
);

   logic [ACC_W-1:0] acc_q;
   logic [ACC_W-1:0] fb_val;
   logic [ACC_W-1:0] sum2;
   logic [ACC_W-1:0] acc_d;

   always_comb begin
      case (fb)
         FB_ACC:  fb_val = acc_q;
         FB_SHR:  fb_val = acc_q >> W;
         default: fb_val = '0;
      endcase
   end

   assign sum2  = sum1 + fb_val;
   assign acc_d = is_logic ? ACC_W'(lword) : sum2;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
      end else if (acc_en && !is_hold) begin
         acc_q <= acc_d;
      end
   end

   assign acc_lo = acc_q[W-1:0];
   assign acc_hi = acc_q[2*W-1:W];

endmodule

// File: rtl/wsmac_datapath.sv
module wsmac_datapath
   import wsmac_pkg::*;
#(
   parameter int WORD_W   = 16,
   parameter int ACC_W    = 40,
   parameter int MUL_IMPL = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CTL_W-1:0]  ctl_word,
   input  logic [WORD_W-1:0] rd_a,
   input  logic [WORD_W-1:0] rd_b,
   output logic              wr_a_en,
   output logic [WORD_W-1:0] wr_a_data,
   output logic              wr_b_en,
   output logic [WORD_W-1:0] wr_b_data
);

   localparam int N_PORTS = 2;

   generate
      if (WORD_W < 2) begin : g_bad_word
         $error("wsmac_datapath: WORD_W must be at least 2");
      end
      if (ACC_W < 2 * WORD_W + 1) begin : g_bad_acc
         $error("wsmac_datapath: ACC_W must hold a doubled product");
      end
      if (MUL_IMPL < 0 || MUL_IMPL > 1) begin : g_bad_mul
         $error("wsmac_datapath: MUL_IMPL must be 0 or 1");
      end
   endgenerate

   ctl_t c;
   assign c = ctl_t'(ctl_word);

   logic [WORD_W-1:0] port_w [N_PORTS];
   logic [WORD_W-1:0] opnd   [N_PORTS];
   src_e              sel    [N_PORTS];

   assign port_w[0] = rd_a;
   assign port_w[1] = rd_b;
   assign sel[0]    = c.src_a;
   assign sel[1]    = c.src_b;

   for (genvar s = 0; s < N_PORTS; s++) begin : g_src
      wsmac_opmux #(.W(WORD_W)) u_mux (
         .sel       (sel[s]),
         .port_word (port_w[s]),
         .operand   (opnd[s])
      );
   end

   logic [ACC_W-1:0]  sum1;
   logic [WORD_W-1:0] lword;
   logic              is_logic;
   logic              is_hold;

   wsmac_arith #(.W(WORD_W), .ACC_W(ACC_W), .MUL_IMPL(MUL_IMPL)) u_arith (
      .op       (c.op),
      .opa      (opnd[0]),
      .opb      (opnd[1]),
      .sum1     (sum1),
      .lword    (lword),
      .is_logic (is_logic),
      .is_hold  (is_hold)
   );

   wsmac_accum #(.W(WORD_W), .ACC_W(ACC_W)) u_accum (
      .clk      (clk),
      .rst_n    (rst_n),
      .acc_en   (c.acc_en),
      .fb       (c.fb),
      .is_logic (is_logic),
      .is_hold  (is_hold),
      .sum1     (sum1),
      .lword    (lword),
      .acc_lo   (wr_a_data),
      .acc_hi   (wr_b_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_a_en <= 1'b0;
         wr_b_en <= 1'b0;
      end else begin
         wr_a_en <= c.wr_a;
         wr_b_en <= c.wr_b;
      end
   end

endmodule

// File: rtl/wsmac_chk.sv
module wsmac_chk
   import wsmac_pkg::*;
#(
   parameter int WORD_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic [CTL_W-1:0]  ctl_word,
   input logic [WORD_W-1:0] rd_a,
   input logic [WORD_W-1:0] rd_b,
   input logic              wr_a_en,
   input logic [WORD_W-1:0] wr_a_data,
   input logic              wr_b_en,
   input logic [WORD_W-1:0] wr_b_data
);

   always @(posedge clk) begin
      if (!rst_n) begin
         AST_RESET_QUIET: assert (!wr_a_en && !wr_b_en && wr_a_data == '0 && wr_b_data == '0); // R1
      end
   end

   AST_HOLD_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && (!$past(ctl_word[9]) || $past(ctl_word[2:1]) == 2'b11))
      |-> ($stable(wr_a_data) && $stable(wr_b_data))); // R7

   AST_ENABLE_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (wr_a_en == $past(ctl_word[10]) && wr_b_en == $past(ctl_word[11]))); // R9

   AST_LOGIC_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(ctl_word[9]) &&
       ($past(ctl_word[2:0]) == 3'd3 || $past(ctl_word[2:0]) == 3'd4 || $past(ctl_word[2:0]) == 3'd5))
      |-> (wr_b_data == '0)); // R6

   AST_AND_ONES_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(ctl_word[9]) && $past(ctl_word[2:0]) == 3'd4 &&
       $past(ctl_word[4:3]) == 2'd3 && $past(ctl_word[6:5]) == 2'd0)
      |-> (wr_a_data == $past(rd_b))); // R2

   AST_OR_ZERO_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(ctl_word[9]) && $past(ctl_word[2:0]) == 3'd5 &&
       $past(ctl_word[4:3]) == 2'd0 && $past(ctl_word[6:5]) == 2'd1)
      |-> (wr_a_data == $past(rd_a))); // R6

   AST_SHIFT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(ctl_word[9]) && $past(ctl_word[2:0]) == 3'd2 &&
       $past(ctl_word[4:3]) == 2'd1 && $past(ctl_word[6:5]) == 2'd1 && $past(ctl_word[8:7]) == 2'd2)
      |-> (wr_a_data == $past(wr_b_data))); // R3

endmodule

bind wsmac_datapath wsmac_chk #(.WORD_W(WORD_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ctl_word  (ctl_word),
   .rd_a      (rd_a),
   .rd_b      (rd_b),
   .wr_a_en   (wr_a_en),
   .wr_a_data (wr_a_data),
   .wr_b_en   (wr_b_en),
   .wr_b_data (wr_b_data)
);

// File: tb/wsmac_datapath_tb.sv
module wsmac_datapath_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] ctl_word = '0;
   logic [15:0] rd_a = '0;
   logic [15:0] rd_b = '0;
   logic        wa_en0, wb_en0, wa_en1, wb_en1;
   logic [15:0] wa_d0, wb_d0, wa_d1, wb_d1;

   int  total = 0;
   int  bad = 0;
   bit  finished = 0;
   logic [39:0] m_acc = '0;
   logic [15:0] lfsr = 16'hACE1;

   always #10 clk = ~clk;

   wsmac_datapath u_dut (
      .clk(clk), .rst_n(rst_n), .ctl_word(ctl_word), .rd_a(rd_a), .rd_b(rd_b),
      .wr_a_en(wa_en0), .wr_a_data(wa_d0), .wr_b_en(wb_en0), .wr_b_data(wb_d0)
   );

   wsmac_datapath #(.MUL_IMPL(1)) u_dut_pp (
      .clk(clk), .rst_n(rst_n), .ctl_word(ctl_word), .rd_a(rd_a), .rd_b(rd_b),
      .wr_a_en(wa_en1), .wr_a_data(wa_d1), .wr_b_en(wb_en1), .wr_b_data(wb_d1)
   );

   function automatic logic [15:0] pick(logic [1:0] src, logic [15:0] port);
      case (src)
         2'd0: return port;
         2'd1: return 16'h0000;
         2'd2: return 16'h0001;
         default: return 16'hFFFF;
      endcase
   endfunction

   function automatic logic [39:0] model(logic [39:0] acc, logic [11:0] c,
                                         logic [15:0] pa, logic [15:0] pb);
      logic [15:0] x, y;
      logic [39:0] f, p;
      x = pick(c[4:3], pa);
      y = pick(c[6:5], pb);
      p = {24'd0, x} * {24'd0, y};
      case (c[8:7])
         2'd1: f = acc;
         2'd2: f = acc >> 16;
         default: f = '0;
      endcase
      if (!c[9]) return acc;
      case (c[2:0])
         3'd0: return p + f;
         3'd1: return p + p + f;
         3'd2: return {24'd0, x} + {24'd0, y} + f;
         3'd3: return {24'd0, x ^ y};
         3'd4: return {24'd0, x & y};
         3'd5: return {24'd0, x | y};
         default: return acc;
      endcase
   endfunction

   function automatic string tag_of(logic [11:0] c);
      if (!c[9]) return "R7";
      case (c[2:0])
         3'd0: return "R3/R2";
         3'd1: return "R4/R2";
         3'd2: return "R5/R2";
         3'd3, 3'd4, 3'd5: return "R6/R2";
         default: return "R7";
      endcase
   endfunction

   task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic step(logic [11:0] c, logic [15:0] pa, logic [15:0] pb, string tag);
      logic [39:0] nxt;
      @(negedge clk);
      ctl_word = c;
      rd_a = pa;
      rd_b = pb;
      nxt = model(m_acc, c, pa, pb);
      @(posedge clk);
      #1;
      m_acc = nxt;
      check({tag, " R8 lo"}, wa_d0, m_acc[15:0]);
      check({tag, " R8 hi"}, wb_d0, m_acc[31:16]);
      check({tag, " R8 lo pp"}, wa_d1, m_acc[15:0]);
      check({tag, " R8 hi pp"}, wb_d1, m_acc[31:16]);
      check("R9 wr_a_en", {15'd0, wa_en0}, {15'd0, c[10]});
      check("R9 wr_b_en", {15'd0, wb_en0}, {15'd0, c[11]});
   endtask

   function automatic logic [11:0] mk(int op, int sa, int sb, int fb, int en, int wa, int wb);
      return {wb[0], wa[0], en[0], fb[1:0], sb[1:0], sa[1:0], op[2:0]};
   endfunction

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check("R1 lo", wa_d0, 16'h0000);
      check("R1 hi", wb_d0, 16'h0000);
      check("R1 en", {14'd0, wa_en0, wb_en0}, 16'h0000);
      @(negedge clk);
      rst_n = 1'b1;

      // sweep of every operation, operand select, feedback code and enable
      for (int op = 0; op < 8; op++)
         for (int sa = 0; sa < 4; sa++)
            for (int sb = 0; sb < 4; sb++)
               for (int fb = 0; fb < 4; fb++)
                  for (int en = 0; en < 2; en++) begin
                     logic [15:0] pa, pb;
                     logic [11:0] c;
                     lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                     pa = lfsr;
                     pb = {lfsr[7:0], lfsr[15:8]} ^ 16'h5A3C;
                     if ((sa + sb + fb) % 4 == 0) begin
                        pa = 16'hFFFF;
                        pb = 16'hFFFF;
                     end
                     c = mk(op, sa, sb, fb, en, int'(lfsr[3]), int'(lfsr[9]));
                     step(c, pa, pb, tag_of(c));
                  end

      // R10: pile doubled full-scale products past bit 31, then shift the top down
      step(mk(2, 1, 1, 0, 1, 0, 0), 16'h0, 16'h0, "R5 clear");
      for (int i = 0; i < 200; i++)
         step(mk(1, 0, 0, 1, 1, 1, 1), 16'hFFFF, 16'hFFFF, "R10 accumulate");
      step(mk(2, 1, 1, 2, 1, 0, 1), 16'h1234, 16'h4321, "R10 shift1");
      step(mk(2, 1, 1, 2, 1, 1, 0), 16'h1234, 16'h4321, "R10 shift2");
      step(mk(6, 0, 0, 1, 1, 1, 1), 16'hFFFF, 16'hFFFF, "R7 hold code");

      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule